// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit side of a packet DMA engine. Software builds a ring of 8-byte buffer descriptors in memory, marks them as owned by hardware and then pulses a trigger. When the controller is enabled, a trigger starts a walk. The walker fetches each owned descriptor, reads the buffer it points to and streams the bytes out on a byte-wide stream. Buffers from chained descriptors form one frame until a descriptor flagged as the frame's end is reached. The walker then writes the descriptor back with ownership returned to software and pulses per-buffer and per-frame event lines.

The ring is a plain list with a wrap flag. The next descriptor is found 8 bytes further on, unless the wrap flag sends the walker back to the programmed ring base. The descriptor pointer is kept between walks. A later trigger therefore resumes at the descriptor where the previous walk stopped. A frame is never allowed to exceed a fixed byte limit: an oversize buffer is cut short and an oversize event is raised. Memory is reached through a single 32-bit request port with one read outstanding.

Top module: `txd_ring_walker`

## Requirements
- R1: A descriptor at address A holds flags in bits 31:16 and length in bits 15:0 of the word at A, and the buffer byte address in the word at A+4. Memory words are big-endian: the byte at an address with low bits 0 sits in bits 31:24.
- R2: A walk starts only when `kick` is pulsed while `ctl_enable` is high. Out of reset, and after a kick while disabled, the block issues no memory request.
- R3: The walk stops at the first descriptor whose flag bit 15 (owned) is clear. That descriptor is not written back and produces no event.
- R4: The bytes of each buffer are streamed in address order, buffers in ring order. `tx_last` is high only on the final byte of a frame, which is the last byte up to and including a buffer whose flag bit 11 (end of frame) is set.
- R5: Each consumed descriptor is written back to its own address with bit 15 cleared and every other flag bit and the length unchanged. Each write-back pulses `ev_buf_done` once.
- R6: `ev_frame_done` pulses once for each consumed descriptor that has flag bit 11 set, and the frame byte count restarts at zero after it.
- R7: When a buffer would take the frame past MAX_FRAME bytes, only the bytes that fit are streamed and `ev_oversize` pulses with that descriptor's `ev_buf_done`.
- R8: After a descriptor with flag bit 13 (wrap) set, the next descriptor is fetched from the ring base. Otherwise it is fetched from the current address plus 8.
- R9: A ring base write clears address bits 1:0 of the written value and reloads the descriptor pointer with the result.
- R10: The descriptor pointer is kept between walks, so a later trigger resumes at the descriptor where the last walk stopped.
- R11: A trigger accepted while a walk is in progress is held and starts exactly one further walk when the current one ends.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R13: While `mem_req` is high and `mem_gnt` is low, the request, its address, direction and write data hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable; gates triggers |
| kick | input | 1 | One-cycle pulse requesting a transmit walk |
| ring_base_wr | input | 1 | Ring base write strobe |
| ring_base_data | input | AW | Ring base value written with the strobe |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data (descriptor write-back) |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Byte is the final one of a frame |
| tx_ready | input | 1 | Sink accepts the byte this cycle |
| ev_buf_done | output | 1 | Pulse per written-back descriptor |
| ev_frame_done | output | 1 | Pulse per completed frame |
| ev_oversize | output | 1 | Pulse when a buffer was cut to the frame limit |
| busy | output | 1 | A walk is in progress |

## Verification
The bench builds the block with its default parameters: a 32-bit address, the big-endian byte lane variant and a 2032-byte frame limit. With the full limit in place, a 2000-byte buffer followed by a 100-byte end buffer brings the cut-off, the oversize event and the restart of the byte count for the next frame within reach. Unaligned buffer starts and zero-length buffers in mid-frame test the byte lane selection and the one-byte hold stage. A randomised sink ready and a grant that stalls one cycle in three run throughout the walks. Separate scenarios hold the grant or the ready low for several cycles to check the hold requirements at the ports.

// File: rtl/txw_pkg.sv
package txw_pkg;

   // Descriptor flag bit positions inside the 16-bit flags field.
   localparam int unsigned FLAG_OWN  = 15;
   localparam int unsigned FLAG_WRAP = 13;
   localparam int unsigned FLAG_LAST = 11;

   // Distance between consecutive descriptors in bytes.
   localparam int unsigned DESC_STRIDE = 8;

   typedef enum logic [3:0] {
      S_IDLE,
      S_HDR_REQ,
      S_HDR_WAIT,
      S_PTR_REQ,
      S_PTR_WAIT,
      S_DAT_REQ,
      S_DAT_WAIT,
      S_SHIFT,
      S_FLUSH,
      S_WB_REQ
   } txw_state_e;

endpackage

// File: rtl/txw_ring_ctl.sv
// Ring base, descriptor pointer and trigger latch.
module txw_ring_ctl #(
   parameter int unsigned AW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable_i,
   input  logic          kick_i,
   input  logic          base_wr_i,
   input  logic [AW-1:0] base_data_i,
   input  logic          walking_i,
   input  logic          advance_i,
   input  logic          wrap_i,
   input  logic          done_i,
   output logic          go_o,
   output logic [AW-1:0] ptr_o
);

   localparam logic [AW-1:0] STRIDE   = AW'(txw_pkg::DESC_STRIDE);
   localparam logic [AW-1:0] ALIGN_MK = ~AW'(3);

   logic [AW-1:0] base_q;
   logic [AW-1:0] ptr_q;
   logic [AW-1:0] base_n;
   logic          reload_q;
   logic          pend_q;
   logic          trig;

   assign trig   = kick_i & enable_i;
   assign go_o   = ~walking_i & (trig | pend_q);
   assign base_n = base_wr_i ? (base_data_i & ALIGN_MK) : base_q;
   assign ptr_o  = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (go_o) begin
         pend_q <= 1'b0;
      end else if (trig) begin
         pend_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else begin
         base_q <= base_n;
      end
   end

   // A base write during a walk is applied when the current
   // descriptor is finished, so its write-back address stays valid.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         reload_q <= 1'b0;
      end else if (base_wr_i && !walking_i) begin
         ptr_q    <= base_n;
         reload_q <= 1'b0;
      end else if (advance_i) begin
         ptr_q    <= (reload_q || wrap_i || base_wr_i) ? base_n : ptr_q + STRIDE;
         reload_q <= 1'b0;
      end else if (done_i && (reload_q || base_wr_i)) begin
         ptr_q    <= base_n;
         reload_q <= 1'b0;
      end else if (base_wr_i) begin
         reload_q <= 1'b1;
      end
   end

endmodule

// File: rtl/txw_frame_clamp.sv
// Running frame byte count and per-buffer length cut.
module txw_frame_clamp #(
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned MAX_FRAME = 2032,
   localparam int unsigned CW       = $clog2(MAX_FRAME + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             end_i,
   output logic [CW-1:0]    len_eff_o,
   output logic             over_o
);

   localparam int unsigned CMP_W = ((LEN_W > CW) ? LEN_W : CW) + 1;

   logic [CW-1:0]    count_q;
   logic [CMP_W-1:0] room;
   logic [CMP_W-1:0] need;

   assign room      = CMP_W'(MAX_FRAME) - CMP_W'(count_q);
   assign need      = CMP_W'(len_i);
   assign over_o    = need > room;
   assign len_eff_o = over_o ? room[CW-1:0] : need[CW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (end_i) begin
         count_q <= '0;
      end else if (load_i) begin
         count_q <= count_q + len_eff_o;
      end
   end

endmodule

// File: rtl/txw_byte_pick.sv
// Selects one byte lane of a memory word.
module txw_byte_pick #(
   parameter bit BIG_ENDIAN = 1'b1
)(
   input  logic [31:0] word_i,
   input  logic [1:0]  off_i,
   output logic [7:0]  byte_o
);

   logic [1:0] lane;

   if (BIG_ENDIAN) begin : g_big
      assign lane = ~off_i;
   end else begin : g_little
      assign lane = off_i;
   end

   assign byte_o = word_i[{lane, 3'b000} +: 8];

endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
   import txw_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned MAX_FRAME = 2032,
   parameter bit          BIG_ENDIAN = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_enable,
   input  logic          kick,
   input  logic          ring_base_wr,
   input  logic [AW-1:0] ring_base_data,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_gnt,
   input  logic          mem_rvalid,
   input  logic [31:0]   mem_rdata,
   output logic [7:0]    tx_data,
   output logic          tx_valid,
   output logic          tx_last,
   input  logic          tx_ready,
   output logic          ev_buf_done,
   output logic          ev_frame_done,
   output logic          ev_oversize,
   output logic          busy
);

   localparam int unsigned LEN_W = 16;
   localparam int unsigned CW    = $clog2(MAX_FRAME + 1);
   localparam logic [AW-1:0] PTR_OFS = AW'(4);

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("txd_ring_walker: AW must lie in 8..32");
   end
   if (MAX_FRAME < 1 || MAX_FRAME >= (1 << LEN_W)) begin : g_bad_max
      $error("txd_ring_walker: MAX_FRAME must fit the length field");
   end

   txw_state_e        st_q;
   logic [15:0]       flags_q;
   logic [LEN_W-1:0]  dlen_q;
   logic [AW-1:0]     baddr_q;
   logic [31:0]       word_q;
   logic [CW-1:0]     rem_q;
   logic              clip_q;
   logic [7:0]        hold_q;
   logic              hold_v_q;
   logic              ev_buf_q;
   logic              ev_frm_q;
   logic              ev_ovr_q;

   logic              go;
   logic [AW-1:0]     ptr;
   logic              walking;
   logic              hdr_fire;
   logic              ptr_fire;
   logic              wb_fire;
   logic              walk_done;
   logic [CW-1:0]     len_eff;
   logic              over;
   logic [7:0]        pick;
   logic              can_move;
   txw_state_e        buf_end_st;

   assign walking   = (st_q != S_IDLE);
   assign hdr_fire  = (st_q == S_HDR_WAIT) && mem_rvalid;
   assign ptr_fire  = (st_q == S_PTR_WAIT) && mem_rvalid;
   assign wb_fire   = (st_q == S_WB_REQ) && mem_gnt;
   assign walk_done = hdr_fire && !mem_rdata[16 + FLAG_OWN];
   assign buf_end_st = flags_q[FLAG_LAST] ? S_FLUSH : S_WB_REQ;
   assign can_move  = !hold_v_q || tx_ready;

   txw_ring_ctl #(.AW(AW)) ring_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (ctl_enable),
      .kick_i      (kick),
      .base_wr_i   (ring_base_wr),
      .base_data_i (ring_base_data),
      .walking_i   (walking),
      .advance_i   (wb_fire),
      .wrap_i      (flags_q[FLAG_WRAP]),
      .done_i      (walk_done),
      .go_o        (go),
      .ptr_o       (ptr)
   );

   txw_frame_clamp #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) clamp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (ptr_fire),
      .len_i     (dlen_q),
      .end_i     (wb_fire && flags_q[FLAG_LAST]),
      .len_eff_o (len_eff),
      .over_o    (over)
   );

   txw_byte_pick #(.BIG_ENDIAN(BIG_ENDIAN)) pick_i (
      .word_i (word_q),
      .off_i  (baddr_q[1:0]),
      .byte_o (pick)
   );

   // Memory request port, driven from state only.
   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = ptr;
      unique case (st_q)
         S_HDR_REQ: begin
            mem_req  = 1'b1;
         end
         S_PTR_REQ: begin
            mem_req  = 1'b1;
            mem_addr = ptr + PTR_OFS;
         end
         S_DAT_REQ: begin
            mem_req  = 1'b1;
            mem_addr = {baddr_q[AW-1:2], 2'b00};
         end
         S_WB_REQ: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
         end
         default: ;
      endcase
   end

   assign mem_wdata = {flags_q & ~(16'h1 << FLAG_OWN), dlen_q};

   // Output stream: the held byte goes out once the next byte of
   // the frame exists (last low) or the frame has ended (last high).
   assign tx_data  = hold_q;
   assign tx_valid = hold_v_q && ((st_q == S_SHIFT) || (st_q == S_FLUSH));
   assign tx_last  = (st_q == S_FLUSH);

   assign ev_buf_done   = ev_buf_q;
   assign ev_frame_done = ev_frm_q;
   assign ev_oversize   = ev_ovr_q;
   assign busy          = walking;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_buf_q <= 1'b0;
         ev_frm_q <= 1'b0;
         ev_ovr_q <= 1'b0;
      end else begin
         ev_buf_q <= wb_fire;
         ev_frm_q <= wb_fire && flags_q[FLAG_LAST];
         ev_ovr_q <= wb_fire && clip_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         flags_q  <= '0;
         dlen_q   <= '0;
         baddr_q  <= '0;
         word_q   <= '0;
         rem_q    <= '0;
         clip_q   <= 1'b0;
         hold_q   <= '0;
         hold_v_q <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (go) st_q <= S_HDR_REQ;
            end
            S_HDR_REQ: begin
               if (mem_gnt) st_q <= S_HDR_WAIT;
            end
            S_HDR_WAIT: begin
               if (mem_rvalid) begin
                  flags_q <= mem_rdata[31:16];
                  dlen_q  <= mem_rdata[15:0];
                  st_q    <= mem_rdata[16 + FLAG_OWN] ? S_PTR_REQ : S_IDLE;
               end
            end
            S_PTR_REQ: begin
               if (mem_gnt) st_q <= S_PTR_WAIT;
            end
            S_PTR_WAIT: begin
               if (mem_rvalid) begin
                  baddr_q <= mem_rdata[AW-1:0];
                  rem_q   <= len_eff;
                  clip_q  <= over;
                  st_q    <= (len_eff == '0) ? buf_end_st : S_DAT_REQ;
               end
            end
            S_DAT_REQ: begin
               if (mem_gnt) st_q <= S_DAT_WAIT;
            end
            S_DAT_WAIT: begin
               if (mem_rvalid) begin
                  word_q <= mem_rdata;
                  st_q   <= S_SHIFT;
               end
            end
            S_SHIFT: begin
               if (can_move) begin
                  hold_q   <= pick;
                  hold_v_q <= 1'b1;
                  baddr_q  <= baddr_q + AW'(1);
                  rem_q    <= rem_q - CW'(1);
                  if (rem_q == CW'(1)) begin
                     st_q <= buf_end_st;
                  end else if (baddr_q[1:0] == 2'b11) begin
                     st_q <= S_DAT_REQ;
                  end
               end
            end
            S_FLUSH: begin
               if (can_move) begin
                  hold_v_q <= 1'b0;
                  st_q     <= S_WB_REQ;
               end
            end
            S_WB_REQ: begin
               if (mem_gnt) st_q <= S_HDR_REQ;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/txw_walker_chk.sv
module txw_walker_chk #(
   parameter int unsigned AW        = 32,
   parameter int unsigned MAX_FRAME = 2032
)(
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata,
   input logic          mem_gnt,
   input logic [7:0]    tx_data,
   input logic          tx_valid,
   input logic          tx_last,
   input logic          tx_ready,
   input logic          ev_buf_done,
   input logic          ev_frame_done,
   input logic          ev_oversize,
   input logic          busy
);

   logic [15:0] fcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q <= '0;
      end else if (tx_valid && tx_ready) begin
         fcnt_q <= tx_last ? '0 : fcnt_q + 16'd1;
      end
   end

   a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));

   a_r12_stream_held: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

   a_r5_wb_returns_owner: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_wdata[31] && (mem_addr[2:0] == 3'b000));

   a_r6_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame_done |-> ev_buf_done);

   a_r7_oversize_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
      ev_oversize |-> ev_buf_done);

   a_r7_frame_cap: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |-> (32'(fcnt_q) < MAX_FRAME));

   a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_valid && !mem_req);

endmodule

bind txd_ring_walker txw_walker_chk #(.AW(AW), .MAX_FRAME(MAX_FRAME)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_addr      (mem_addr),
   .mem_wdata     (mem_wdata),
   .mem_gnt       (mem_gnt),
   .tx_data       (tx_data),
   .tx_valid      (tx_valid),
   .tx_last       (tx_last),
   .tx_ready      (tx_ready),
   .ev_buf_done   (ev_buf_done),
   .ev_frame_done (ev_frame_done),
   .ev_oversize   (ev_oversize),
   .busy          (busy)
);

// File: tb/txd_ring_walker_tb_top.sv
module txd_ring_walker_tb_top;

   localparam logic [15:0] F_OWN  = 16'h8000;
   localparam logic [15:0] F_WRAP = 16'h2000;
   localparam logic [15:0] F_LAST = 16'h0800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_enable = 1'b1;
   logic        kick = 1'b0;
   logic        ring_base_wr = 1'b0;
   logic [31:0] ring_base_data = '0;
   logic        mem_req, mem_we, mem_gnt;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [7:0]  tx_data;
   logic        tx_valid, tx_last;
   logic        tx_ready = 1'b1;
   logic        ev_buf_done, ev_frame_done, ev_oversize, busy;

   logic        gnt_en = 1'b1;
   logic        gnt_stall = 1'b0;
   logic        rdy_stall = 1'b0;
   logic [7:0]  lfsr = 8'hA5;
   int          cyc = 0;

   logic [31:0] mem [0:4095];
   logic        rd_pend = 1'b0;
   logic [31:0] rd_word = '0;

   logic [8:0]  exp_q [$];
   int          mism = 0;
   int          n_buf = 0, n_frm = 0, n_ovr = 0;
   int          n_req = 0, n_watch = 0;
   logic [31:0] watch_addr = '1;

   int          checks = 0;
   int          errors = 0;

   always #10ns clk = ~clk;

   txd_ring_walker dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .kick(kick),
      .ring_base_wr(ring_base_wr), .ring_base_data(ring_base_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_last(tx_last), .tx_ready(tx_ready), .ev_buf_done(ev_buf_done),
      .ev_frame_done(ev_frame_done), .ev_oversize(ev_oversize), .busy(busy)
   );

   assign mem_gnt = mem_req & gnt_en;

   function automatic logic [7:0] pat(input logic [31:0] a);
      logic [7:0] t;
      t = a[15:8] * 8'd37;
      return a[7:0] ^ t;
   endfunction

   // Memory, sink and event monitor: all act on the falling edge.
   always @(negedge clk) begin
      cyc = cyc + 1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      gnt_en = !gnt_stall && (cyc % 3 != 2);
      tx_ready = !rdy_stall && (lfsr[0] || lfsr[3]);
      mem_rvalid = 1'b0;
      if (rd_pend) begin
         mem_rvalid = 1'b1;
         mem_rdata = rd_word;
         rd_pend = 1'b0;
      end
      if (mem_req) n_req++;
      if (mem_req && gnt_en) begin
         if (mem_we) begin
            mem[mem_addr[13:2]] = mem_wdata;
         end else begin
            rd_pend = 1'b1;
            rd_word = mem[mem_addr[13:2]];
            if (mem_addr == watch_addr) n_watch++;
         end
      end
      if (tx_valid && tx_ready) begin
         if (exp_q.size() == 0) begin
            mism++;
         end else if (exp_q.pop_front() != {tx_last, tx_data}) begin
            mism++;
         end
      end
      if (ev_buf_done) n_buf++;
      if (ev_frame_done) n_frm++;
      if (ev_oversize) n_ovr++;
   end

   task automatic check_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_stats();
      mism = 0; n_buf = 0; n_frm = 0; n_ovr = 0; n_req = 0; n_watch = 0;
      exp_q.delete();
   endtask

   task automatic set_desc(input logic [31:0] a, input logic [15:0] fl,
                           input logic [15:0] len, input logic [31:0] b);
      mem[a[13:2]]     = {fl, len};
      mem[a[13:2] + 1] = b;
   endtask

   task automatic push_bytes(input logic [31:0] b, input int n, input bit ends);
      for (int i = 0; i < n; i++)
         exp_q.push_back({ends && (i == n - 1), pat(b + 32'(i))});
   endtask

   task automatic pulse_kick();
      @(negedge clk) kick = 1'b1;
      @(negedge clk) kick = 1'b0;
   endtask

   task automatic write_base(input logic [31:0] v);
      @(negedge clk) begin ring_base_wr = 1'b1; ring_base_data = v; end
      @(negedge clk) ring_base_wr = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int quiet = 0;
      int n = 0;
      while (quiet < 6 && n < 30000) begin
         @(negedge clk);
         quiet = busy ? 0 : quiet + 1;
         n++;
      end
      if (n >= 30000) check_eq(req, "walk did not finish", 0, 1);
   endtask

   task automatic check_stream(input string req);
      check_eq(req, "stream mismatches", 32'(mism), 0);
      check_eq(req, "bytes still expected", 32'(exp_q.size()), 0);
   endtask

   task automatic t_reset();
      check_eq("R2", "tx_valid after reset", 32'(tx_valid), 0);
      check_eq("R2", "mem_req after reset", 32'(mem_req), 0);
      check_eq("R2", "busy after reset", 32'(busy), 0);
   endtask

   task automatic t_single();
      clear_stats();
      set_desc(32'h100, F_OWN | F_LAST, 16'd5, 32'h1001);
      set_desc(32'h108, 16'h0000, 16'd9, 32'h1100);
      watch_addr = 32'h108;
      write_base(32'h100);
      push_bytes(32'h1001, 5, 1'b1);
      pulse_kick();
      wait_idle("R4");
      check_stream("R1 R4");
      check_eq("R5", "buffer events", 32'(n_buf), 1);
      check_eq("R6", "frame events", 32'(n_frm), 1);
      check_eq("R5", "written back word", mem[32'h100 >> 2], {F_LAST, 16'd5});
      check_eq("R3", "unowned descriptor untouched", mem[32'h108 >> 2], {16'h0, 16'd9});
      check_eq("R3", "unowned descriptor fetched once", 32'(n_watch), 1);
   endtask

   task automatic t_chain();
      clear_stats();
      set_desc(32'h200, F_OWN, 16'd3, 32'h1102);
      set_desc(32'h208, F_OWN, 16'd0, 32'h1200);
      set_desc(32'h210, F_OWN | F_LAST, 16'd6, 32'h1303);
      set_desc(32'h218, 16'h0000, 16'd0, 32'h0);
      write_base(32'h200);
      push_bytes(32'h1102, 3, 1'b0);
      push_bytes(32'h1303, 6, 1'b1);
      pulse_kick();
      wait_idle("R4");
      check_stream("R4");
      check_eq("R5", "buffer events in chain", 32'(n_buf), 3);
      check_eq("R6", "one frame for chain", 32'(n_frm), 1);
      check_eq("R5", "zero-length written back", mem[32'h208 >> 2], {16'h0, 16'd0});
   endtask

   task automatic t_wrap();
      clear_stats();
      set_desc(32'h300, F_OWN | F_LAST | F_WRAP, 16'd4, 32'h1400);
      set_desc(32'h308, F_OWN | F_LAST, 16'd4, 32'h1500);
      watch_addr = 32'h300;
      write_base(32'h300);
      push_bytes(32'h1400, 4, 1'b1);
      pulse_kick();
      wait_idle("R8");
      check_stream("R8");
      check_eq("R8", "slot after wrap descriptor untouched", 32'(mem[32'h308 >> 2][31]), 1);
      check_eq("R8", "base fetched again after wrap", 32'(n_watch), 2);
      check_eq("R5", "wrap flag kept on write-back", mem[32'h300 >> 2], {F_LAST | F_WRAP, 16'd4});
   endtask

   task automatic t_resume();
      clear_stats();
      set_desc(32'h380, F_OWN | F_LAST, 16'd3, 32'h1600);
      set_desc(32'h388, 16'h0000, 16'd0, 32'h0);
      write_base(32'h380);
      push_bytes(32'h1600, 3, 1'b1);
      pulse_kick();
      wait_idle("R10");
      clear_stats();
      set_desc(32'h388, F_OWN | F_LAST, 16'd2, 32'h1700);
      set_desc(32'h390, 16'h0000, 16'd0, 32'h0);
      push_bytes(32'h1700, 2, 1'b1);
      pulse_kick();
      wait_idle("R10");
      check_stream("R10");
      check_eq("R10", "resumed walk buffer events", 32'(n_buf), 1);
      check_eq("R10", "resumed descriptor written back", mem[32'h388 >> 2], {F_LAST, 16'd2});
   endtask

   task automatic t_disabled();
      clear_stats();
      set_desc(32'h400, F_OWN | F_LAST, 16'd2, 32'h1780);
      set_desc(32'h408, 16'h0000, 16'd0, 32'h0);
      write_base(32'h400);
      ctl_enable = 1'b0;
      pulse_kick();
      repeat (40) @(negedge clk);
      check_eq("R2", "requests while disabled", 32'(n_req), 0);
      check_eq("R2", "descriptor still owned", 32'(mem[32'h400 >> 2][31]), 1);
      ctl_enable = 1'b1;
      push_bytes(32'h1780, 2, 1'b1);
      pulse_kick();
      wait_idle("R2");
      check_eq("R2", "walk after enable", 32'(n_buf), 1);
      check_stream("R2");
   endtask

   task automatic t_base_mask();
      clear_stats();
      set_desc(32'h480, F_OWN | F_LAST, 16'd2, 32'h1800);
      set_desc(32'h488, 16'h0000, 16'd0, 32'h0);
      write_base(32'h483);
      push_bytes(32'h1800, 2, 1'b1);
      pulse_kick();
      wait_idle("R9");
      check_stream("R9");
      check_eq("R9", "aligned slot written back", mem[32'h480 >> 2], {F_LAST, 16'd2});
   endtask

   task automatic t_clamp();
      clear_stats();
      set_desc(32'h500, F_OWN, 16'd2000, 32'h2000);
      set_desc(32'h508, F_OWN | F_LAST, 16'd100, 32'h3000);
      set_desc(32'h510, F_OWN | F_LAST, 16'd3, 32'h1900);
      set_desc(32'h518, 16'h0000, 16'd0, 32'h0);
      write_base(32'h500);
      push_bytes(32'h2000, 2000, 1'b0);
      push_bytes(32'h3000, 32, 1'b1);
      push_bytes(32'h1900, 3, 1'b1);
      pulse_kick();
      wait_idle("R7");
      check_stream("R7");
      check_eq("R7", "oversize events", 32'(n_ovr), 1);
      check_eq("R6", "frames after cut", 32'(n_frm), 2);
      check_eq("R5", "buffer events with cut", 32'(n_buf), 3);
      check_eq("R5", "cut descriptor keeps length", mem[32'h508 >> 2], {F_LAST, 16'd100});
   endtask

   task automatic t_latch();
      clear_stats();
      set_desc(32'h580, F_OWN | F_LAST, 16'd40, 32'h1A00);
      set_desc(32'h588, 16'h0000, 16'd0, 32'h0);
      watch_addr = 32'h588;
      write_base(32'h580);
      push_bytes(32'h1A00, 40, 1'b1);
      pulse_kick();
      repeat (15) @(negedge clk);
      check_eq("R11", "walk running at second trigger", 32'(busy), 1);
      pulse_kick();
      wait_idle("R11");
      check_eq("R11", "stop descriptor fetched twice", 32'(n_watch), 2);
      check_eq("R11", "buffer events", 32'(n_buf), 1);
      check_stream("R11");
   endtask

   task automatic t_backpressure();
      logic [7:0] d0;
      int n = 0;
      clear_stats();
      set_desc(32'h600, F_OWN | F_LAST, 16'd6, 32'h1B00);
      set_desc(32'h608, 16'h0000, 16'd0, 32'h0);
      write_base(32'h600);
      push_bytes(32'h1B00, 6, 1'b1);
      rdy_stall = 1'b1;
      pulse_kick();
      while (!tx_valid && n < 200) begin @(negedge clk); n++; end
      d0 = tx_data;
      repeat (8) @(negedge clk);
      check_eq("R12", "valid held under stall", 32'(tx_valid), 1);
      check_eq("R12", "data held under stall", 32'(tx_data), 32'(d0));
      rdy_stall = 1'b0;
      wait_idle("R12");
      check_stream("R12");
   endtask

   task automatic t_grant_hold();
      logic [31:0] a0;
      int n = 0;
      clear_stats();
      set_desc(32'h680, F_OWN | F_LAST, 16'd1, 32'h1C00);
      set_desc(32'h688, 16'h0000, 16'd0, 32'h0);
      write_base(32'h680);
      push_bytes(32'h1C00, 1, 1'b1);
      gnt_stall = 1'b1;
      pulse_kick();
      while (!mem_req && n < 50) begin @(negedge clk); n++; end
      a0 = mem_addr;
      repeat (6) @(negedge clk);
      check_eq("R13", "request held without grant", 32'(mem_req), 1);
      check_eq("R13", "address held without grant", mem_addr, a0);
      gnt_stall = 1'b0;
      wait_idle("R13");
      check_stream("R13");
      check_eq("R13", "buffer events after stall", 32'(n_buf), 1);
   endtask

   initial begin
      for (int w = 0; w < 4096; w++)
         mem[w] = {pat(32'(4 * w)), pat(32'(4 * w + 1)),
                   pat(32'(4 * w + 2)), pat(32'(4 * w + 3))};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_chain();
      t_wrap();
      t_resume();
      t_disabled();
      t_base_mask();
      t_clamp();
      t_latch();
      t_backpressure();
      t_grant_hold();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule